// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

This block is a programmable tone source. An N-bit phase register is advanced by a frequency word on every enabled clock, wrapping freely modulo 2^N. The running phase appears at the outputs in three forms at once: as a ramp (the phase register value), as a square wave (its top bit), and as a signed sine and cosine pair of fixed amplitude. Output frequency is `step * f_clk / 2^N`, which is usable up to half the clock rate and resolves very fine frequency steps.

The sine and cosine are produced by an unrolled, pipelined CORDIC rotator with one micro-rotation per register stage instead of a lookup table. The two top phase bits choose the quadrant; the rotator only ever turns through less than a right angle and the quadrant is restored by swapping and negating at the end. The starting vector is pre-scaled by the inverse CORDIC gain, so no multiplier is needed. The ramp and square outputs travel down the same pipeline, so every output sample describes one and the same phase value. A valid flag rises once the pipeline holds data taken after reset.

Typical uses are local oscillators for mixers and modulators, reference tones inside phase-locked loops, and test-signal generators.

Top module: `nco_dds_quad`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are all zero: `out_valid`=0, `saw_out`=0, `sq_out`=0, `sin_out`=0, `cos_out`=0.
- R2: With `en` high, the phase register grows by `step` at each clock edge, modulo 2^ACC_W with no saturation, so successive valid `saw_out` samples differ by exactly `step` (mod 2^ACC_W).
- R3: With `en` low at an edge, the phase register keeps its value; the corresponding `saw_out` sample repeats the previous one.
- R4: `sq_out` equals bit ACC_W-1 of `saw_out` in every valid sample.
- R5: With phase p = `saw_out`, `sin_out` and `cos_out` stay within 6 LSB of AMP·sin(2πp/2^ACC_W) and AMP·cos(2πp/2^ACC_W), AMP = 2^(OUT_W-1) - 16, for all four quadrants (top two phase bits 00, 01, 10, 11 = 0°, 90°, 180°, 270°).
- R6: The magnitude sqrt(sin² + cos²) of every valid sample stays within 8 LSB of AMP.
- R7: After reset is released, `out_valid` rises exactly STAGES+2 clock edges later, that first valid sample shows phase 0, and `out_valid` then stays high until the next reset.
- R8: A new `step` value is applied from the next clock edge onward without disturbing the phase already accumulated, so the phase is continuous across frequency changes.
- R9: Over a window of W clocks, the count of rising edges on `sq_out` is within one of step·W/2^ACC_W, also for a step that does not divide 2^ACC_W (edge jitter is left uncorrected).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Phase advance enable |
| step | input | ACC_W | Frequency word added to the phase each enabled clock |
| saw_out | output | ACC_W | Ramp output: delayed phase register value |
| sq_out | output | 1 | Square output: top phase bit, same delay |
| sin_out | output | OUT_W | Signed sine sample of the same phase |
| cos_out | output | OUT_W | Signed cosine sample of the same phase |
| out_valid | output | 1 | High once the pipeline carries post-reset samples |

## Verification
The bench drives the oscillator with a coarse power-of-two step that sweeps all four quadrants in a few hundred clocks, an odd step that never divides the phase range, a step that wraps nearly a full turn per clock, and a step close to half the clock rate; together these separate errors in the wrap arithmetic, in the quadrant fold and swap, and in the rotation angle constants. Every valid sample is compared against an independent phase model for the ramp and square, and against a real-valued sine, cosine and magnitude. Holding `en` low mid-run and changing `step` without reset tell a frozen or restarted phase apart from a continuous one, and a square-edge count over a long window with the odd step confirms the average frequency despite edge jitter.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;

    localparam real TWO_PI          = 6.283185307179586;
    localparam real CORDIC_INV_GAIN = 0.6072529350088813;

    // Quadrant selected by the two top phase bits; the order is behaviour.
    typedef enum logic [1:0] {
        QD_0   = 2'd0,
        QD_90  = 2'd1,
        QD_180 = 2'd2,
        QD_270 = 2'd3
    } quadrant_e;

    // Angle of micro-rotation idx, atan(2^-idx), as a fraction of a full
    // turn scaled to 2^zw, rounded to nearest.
    function automatic int rot_angle(input int idx, input int zw);
        real a;
        a = $atan(1.0 / (2.0 ** idx));
        return $rtoi(a / TWO_PI * (2.0 ** zw) + 0.5);
    endfunction

    // Pre-scaled starting x so the rotator ends at amplitude amp (with gb
    // guard bits) without a final multiply.
    function automatic int seed_x(input int amp, input int gb);
        return $rtoi(real'(amp) * (2.0 ** gb) * CORDIC_INV_GAIN + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int XW    = 20,
    parameter int ZW    = 20,
    parameter int GB    = 2,
    parameter int AMP   = 32752
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        step,
    output logic                    p_valid,
    output quadrant_e               p_quad,
    output logic                    p_sq,
    output logic [ACC_W-1:0]        p_phase,
    output logic signed [XW-1:0]    p_x,
    output logic signed [XW-1:0]    p_y,
    output logic signed [ZW-1:0]    p_z
);

    localparam int X0     = seed_x(AMP, GB);
    localparam int FRAC_W = ZW - 2;

    typedef struct packed {
        logic [ACC_W-1:0]     acc;
        logic                 valid;
        quadrant_e            quad;
        logic                 sq;
        logic [ACC_W-1:0]     phase;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.acc   = en ? st_q.acc + step : st_q.acc;
        st_d.valid = 1'b1;
        st_d.quad  = quadrant_e'(st_q.acc[ACC_W-1 -: 2]);
        st_d.sq    = st_q.acc[ACC_W-1];
        st_d.phase = st_q.acc;
        st_d.x     = XW'(X0);
        st_d.y     = '0;
        st_d.z     = $signed({2'b00, st_q.acc[ACC_W-3 -: FRAC_W]});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p_valid = st_q.valid;
    assign p_quad  = st_q.quad;
    assign p_sq    = st_q.sq;
    assign p_phase = st_q.phase;
    assign p_x     = st_q.x;
    assign p_y     = st_q.y;
    assign p_z     = st_q.z;

    // R2: enabled edges advance the phase by the step, modulo 2^ACC_W
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |-> (st_q.acc == ACC_W'($past(st_q.acc) + $past(step))));

    // R3: disabled edges leave the phase alone
    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> (st_q.acc == $past(st_q.acc)));

endmodule

// File: rtl/nco_cordic_stage.sv
`timescale 1ns/1ps
module nco_cordic_stage
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int XW    = 20,
    parameter int ZW    = 20,
    parameter int IDX   = 0,
    parameter bit LAST  = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    i_valid,
    input  quadrant_e               i_quad,
    input  logic                    i_sq,
    input  logic [ACC_W-1:0]        i_phase,
    input  logic signed [XW-1:0]    i_x,
    input  logic signed [XW-1:0]    i_y,
    input  logic signed [ZW-1:0]    i_z,
    output logic                    o_valid,
    output quadrant_e               o_quad,
    output logic                    o_sq,
    output logic [ACC_W-1:0]        o_phase,
    output logic signed [XW-1:0]    o_x,
    output logic signed [XW-1:0]    o_y,
    output logic signed [ZW-1:0]    o_z
);

    localparam int                   ANG_I = rot_angle(IDX, ZW);
    localparam logic signed [ZW-1:0] ANG   = ZW'(ANG_I);
    localparam logic signed [ZW-1:0] ZTOL  = ZW'(48);

    typedef struct packed {
        logic                 valid;
        quadrant_e            quad;
        logic                 sq;
        logic [ACC_W-1:0]     phase;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } rot_state_t;

    rot_state_t rs_d, rs_q;
    logic signed [XW-1:0] x_shr, y_shr;

    always_comb begin
        x_shr       = i_x >>> IDX;
        y_shr       = i_y >>> IDX;
        rs_d.valid  = i_valid;
        rs_d.quad   = i_quad;
        rs_d.sq     = i_sq;
        rs_d.phase  = i_phase;
        if (i_z >= 0) begin
            rs_d.x = i_x - y_shr;
            rs_d.y = i_y + x_shr;
            rs_d.z = i_z - ANG;
        end else begin
            rs_d.x = i_x + y_shr;
            rs_d.y = i_y - x_shr;
            rs_d.z = i_z + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign o_valid = rs_q.valid;
    assign o_quad  = rs_q.quad;
    assign o_sq    = rs_q.sq;
    assign o_phase = rs_q.phase;
    assign o_x     = rs_q.x;
    assign o_y     = rs_q.y;
    assign o_z     = rs_q.z;

    generate
        if (LAST) begin : g_residual
            // R5: the rotator has converged: residual angle is near zero
            assert_residual_R5: assert property (@(posedge clk) disable iff (rst)
                o_valid |-> ((o_z < ZTOL) && (o_z > -ZTOL)));
        end
    endgenerate

endmodule

// File: rtl/nco_quad_out.sv
`timescale 1ns/1ps
module nco_quad_out
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int OUT_W = 16,
    parameter int XW    = 20,
    parameter int GB    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     i_valid,
    input  quadrant_e                i_quad,
    input  logic                     i_sq,
    input  logic [ACC_W-1:0]         i_phase,
    input  logic signed [XW-1:0]     i_x,
    input  logic signed [XW-1:0]     i_y,
    output logic                     o_valid,
    output logic                     o_sq,
    output logic [ACC_W-1:0]         o_saw,
    output logic signed [OUT_W-1:0]  o_sin,
    output logic signed [OUT_W-1:0]  o_cos
);

    localparam logic signed [XW-1:0] HALF  = XW'(1 << (GB - 1));
    localparam logic signed [XW-1:0] MAXV  = XW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [XW-1:0] MINV  = -MAXV;
    localparam logic signed [OUT_W-1:0] SIGN_TOL = -OUT_W'(4);

    typedef struct packed {
        logic                    valid;
        logic                    sq;
        logic [ACC_W-1:0]        saw;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } out_state_t;

    out_state_t os_d, os_q;
    logic signed [XW-1:0] sin_f, cos_f;

    function automatic logic signed [OUT_W-1:0] shrink(input logic signed [XW-1:0] v);
        logic signed [XW-1:0] r;
        r = (v + HALF) >>> GB;
        if (r > MAXV) begin
            r = MAXV;
        end else if (r < MINV) begin
            r = MINV;
        end
        return r[OUT_W-1:0];
    endfunction

    always_comb begin
        unique case (i_quad)
            QD_0: begin
                sin_f = i_y;
                cos_f = i_x;
            end
            QD_90: begin
                sin_f = i_x;
                cos_f = -i_y;
            end
            QD_180: begin
                sin_f = -i_y;
                cos_f = -i_x;
            end
            default: begin
                sin_f = -i_x;
                cos_f = i_y;
            end
        endcase
        os_d.valid = i_valid;
        os_d.sq    = i_sq;
        os_d.saw   = i_phase;
        os_d.s     = shrink(sin_f);
        os_d.c     = shrink(cos_f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign o_valid = os_q.valid;
    assign o_sq    = os_q.sq;
    assign o_saw   = os_q.saw;
    assign o_sin   = os_q.s;
    assign o_cos   = os_q.c;

    // R5: first-quadrant inputs leave both outputs non-negative (small slack)
    assert_quad0_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_quad == QD_0) |=> ((o_sin >= SIGN_TOL) && (o_cos >= SIGN_TOL)));

    // R5: third-quadrant inputs leave both outputs non-positive (small slack)
    assert_quad2_sign_R5: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_quad == QD_180) |=> ((o_sin <= -SIGN_TOL) && (o_cos <= -SIGN_TOL)));

endmodule

// File: rtl/nco_dds_quad.sv
`timescale 1ns/1ps
module nco_dds_quad
    import nco_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int STAGES = 16,
    parameter int GB     = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [ACC_W-1:0]         step,
    output logic [ACC_W-1:0]         saw_out,
    output logic                     sq_out,
    output logic signed [OUT_W-1:0]  sin_out,
    output logic signed [OUT_W-1:0]  cos_out,
    output logic                     out_valid
);

    localparam int AMP = (1 << (OUT_W - 1)) - 16;
    localparam int XW  = OUT_W + GB + 2;
    localparam int ZW  = STAGES + 4;

    logic                 c_valid [0:STAGES];
    quadrant_e            c_quad  [0:STAGES];
    logic                 c_sq    [0:STAGES];
    logic [ACC_W-1:0]     c_phase [0:STAGES];
    logic signed [XW-1:0] c_x     [0:STAGES];
    logic signed [XW-1:0] c_y     [0:STAGES];
    logic signed [ZW-1:0] c_z     [0:STAGES];

    nco_phase_acc #(
        .ACC_W (ACC_W),
        .XW    (XW),
        .ZW    (ZW),
        .GB    (GB),
        .AMP   (AMP)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step    (step),
        .p_valid (c_valid[0]),
        .p_quad  (c_quad[0]),
        .p_sq    (c_sq[0]),
        .p_phase (c_phase[0]),
        .p_x     (c_x[0]),
        .p_y     (c_y[0]),
        .p_z     (c_z[0])
    );

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_rot
            nco_cordic_stage #(
                .ACC_W (ACC_W),
                .XW    (XW),
                .ZW    (ZW),
                .IDX   (k),
                .LAST  (k == STAGES - 1)
            ) u_stage (
                .clk     (clk),
                .rst     (rst),
                .i_valid (c_valid[k]),
                .i_quad  (c_quad[k]),
                .i_sq    (c_sq[k]),
                .i_phase (c_phase[k]),
                .i_x     (c_x[k]),
                .i_y     (c_y[k]),
                .i_z     (c_z[k]),
                .o_valid (c_valid[k+1]),
                .o_quad  (c_quad[k+1]),
                .o_sq    (c_sq[k+1]),
                .o_phase (c_phase[k+1]),
                .o_x     (c_x[k+1]),
                .o_y     (c_y[k+1]),
                .o_z     (c_z[k+1])
            );
        end
    endgenerate

    nco_quad_out #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .XW    (XW),
        .GB    (GB)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .i_valid (c_valid[STAGES]),
        .i_quad  (c_quad[STAGES]),
        .i_sq    (c_sq[STAGES]),
        .i_phase (c_phase[STAGES]),
        .i_x     (c_x[STAGES]),
        .i_y     (c_y[STAGES]),
        .o_valid (out_valid),
        .o_sq    (sq_out),
        .o_saw   (saw_out),
        .o_sin   (sin_out),
        .o_cos   (cos_out)
    );

    // R1: a reset edge clears the valid flag and the ramp
    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && saw_out == '0 && !sq_out));

    // R4: square output tracks the ramp's top bit
    assert_sq_msb_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sq_out == saw_out[ACC_W-1]));

    // R7: once valid, stays valid until reset
    assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

endmodule

// File: tb/sim_nco_dds_quad.sv
`timescale 1ns/1ps
module sim_nco_dds_quad;

    localparam int  ACC_W  = 32;
    localparam int  OUT_W  = 16;
    localparam int  STAGES = 16;
    localparam int  LAT    = STAGES + 2;
    localparam real AMP    = 32752.0;
    localparam real TWO_PI = 6.283185307179586;
    localparam real TURN   = 4294967296.0;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en  = 1'b0;
    logic [ACC_W-1:0]        step = '0;
    logic [ACC_W-1:0]        saw_w;
    logic                    sq_w;
    logic signed [OUT_W-1:0] sin_w;
    logic signed [OUT_W-1:0] cos_w;
    logic                    vld_w;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    nco_dds_quad u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .step      (step),
        .saw_out   (saw_w),
        .sq_out    (sq_w),
        .sin_out   (sin_w),
        .cos_out   (cos_w),
        .out_valid (vld_w)
    );

    // Phase model from the requirements: the phase after an edge appears
    // at the outputs LAT edges later.
    logic [ACC_W-1:0] m_acc;
    logic [ACC_W-1:0] m_ph [0:LAT-1];
    logic             m_v  [0:LAT-1];

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= '0;
            for (int k = 0; k < LAT; k++) begin
                m_ph[k] <= '0;
                m_v[k]  <= 1'b0;
            end
        end else begin
            m_ph[0] <= m_acc;
            m_v[0]  <= 1'b1;
            for (int k = 1; k < LAT; k++) begin
                m_ph[k] <= m_ph[k-1];
                m_v[k]  <= m_v[k-1];
            end
            if (en) m_acc <= m_acc + step;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    // Compare one output sample against the model; tag names the scenario.
    task automatic check_sample(input string tag);
        real es, ec, ds, dc, mag;
        check(vld_w == m_v[LAT-1], "R7", {tag, " valid"}, real'(vld_w), real'(m_v[LAT-1]));
        if (vld_w && m_v[LAT-1]) begin
            check(saw_w == m_ph[LAT-1], "R2", {tag, " ramp"}, real'(saw_w), real'(m_ph[LAT-1]));
            check(sq_w == saw_w[ACC_W-1], "R4", {tag, " square"}, real'(sq_w), real'(saw_w[ACC_W-1]));
            es = AMP * $sin(TWO_PI * real'(saw_w) / TURN);
            ec = AMP * $cos(TWO_PI * real'(saw_w) / TURN);
            ds = real'(sin_w) - es;
            dc = real'(cos_w) - ec;
            if (ds < 0.0) ds = -ds;
            if (dc < 0.0) dc = -dc;
            check(ds <= 6.0, "R5", {tag, " sine"}, real'(sin_w), es);
            check(dc <= 6.0, "R5", {tag, " cosine"}, real'(cos_w), ec);
            mag = $sqrt(real'(sin_w) * real'(sin_w) + real'(cos_w) * real'(cos_w));
            check((mag - AMP <= 8.0) && (AMP - mag <= 8.0), "R6", {tag, " magnitude"}, mag, AMP);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_sample(tag);
        end
    endtask

    // R1: outputs held at zero during reset
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (3) @(negedge clk);
        check(!vld_w, "R1", "reset valid", real'(vld_w), 0.0);
        check(saw_w == '0, "R1", "reset ramp", real'(saw_w), 0.0);
        check(!sq_w, "R1", "reset square", real'(sq_w), 0.0);
        check(sin_w == '0, "R1", "reset sine", real'(sin_w), 0.0);
        check(cos_w == '0, "R1", "reset cosine", real'(cos_w), 0.0);
    endtask

    // R7: fill latency and first sample after reset release
    task automatic t_latency(input logic [ACC_W-1:0] s);
        int edges;
        step  = s;
        en    = 1'b1;
        rst   = 1'b0;
        edges = 0;
        while (edges < 60) begin
            @(negedge clk);
            edges++;
            if (vld_w) break;
        end
        check(edges == LAT, "R7", "fill latency", real'(edges), real'(LAT));
        check(saw_w == '0, "R7", "first phase", real'(saw_w), 0.0);
        run(4, "R7 start");
    endtask

    // R2/R5: sweep with a given step
    task automatic t_sweep(input logic [ACC_W-1:0] s, input int n, input string tag);
        step = s;
        run(n, tag);
    endtask

    // R3: hold the phase with en low
    task automatic t_hold();
        logic [ACC_W-1:0] first;
        int same;
        step = 32'h0200_0000;
        run(LAT, "R3 pre");
        en = 1'b0;
        run(7, "R3 off");
        en = 1'b1;
        run(LAT - 7, "R3 drain");
        first = saw_w;
        same  = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_sample("R3 frozen");
            if (saw_w == first) same++;
        end
        check(same == 7, "R3", "frozen samples", real'(same), 7.0);
        run(LAT, "R3 after");
    endtask

    // R8: step change without reset keeps phase continuous
    task automatic t_change();
        logic [ACC_W-1:0] prev;
        logic [ACC_W-1:0] before_step;
        before_step = 32'h0100_0000;
        step = before_step;
        run(LAT + 5, "R8 old step");
        step = 32'h0345_6789;
        run(LAT - 1, "R8 transit");
        prev = saw_w;
        @(negedge clk);
        check_sample("R8 switch");
        check(saw_w - prev == before_step, "R8", "last old increment",
              real'(saw_w - prev), real'(before_step));
        prev = saw_w;
        @(negedge clk);
        check_sample("R8 switch");
        check(saw_w - prev == 32'h0345_6789, "R8", "first new increment",
              real'(saw_w - prev), real'(32'h0345_6789));
        run(40, "R8 new step");
    endtask

    // R9: average square frequency with a step that does not divide 2^N
    task automatic t_freq();
        int  rises;
        bit  prev;
        real expct;
        step = 32'h0123_4567;
        run(LAT + 2, "R9 settle");
        prev  = sq_w;
        rises = 0;
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            check_sample("R9 window");
            if (sq_w && !prev) rises++;
            prev = sq_w;
        end
        expct = real'(32'h0123_4567) * 4096.0 / TURN;
        check((real'(rises) - expct <= 1.0) && (expct - real'(rises) <= 1.0),
              "R9", "square rising edges", real'(rises), expct);
    endtask

    initial begin
        t_reset();
        t_latency(32'h0100_0000);
        t_sweep(32'h0100_0000, 300, "R5 quadrants");
        t_sweep(32'h0123_4567, 300, "R2 odd step");
        t_sweep(32'hF000_0001, 200, "R2 wrap");
        t_sweep(32'h7FF0_0000, 100, "R5 near half rate");
        t_hold();
        t_change();
        t_freq();
        t_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule